// File: doc/BRIEF.md
# Dateline Virtual-Channel Route Selector for a Unidirectional Torus

This block decides, for one node of a unidirectional k-ary n-cube with wrap-around links, where a packet header goes next. A header carrying the node's own coordinates, the destination coordinates and the packet's present virtual-channel level is captured in a one-entry register through a valid/ready handshake. From that held header the block combinationally selects the outgoing physical port and the virtual-channel level the packet must use on that port, or flags that the packet has arrived and must be ejected.

Routing is dimension-ordered: the lowest-numbered dimension whose coordinate still differs from the destination is always resolved first, and every link in a dimension moves the coordinate up by one, modulo k. When the chosen hop leaves a node whose coordinate in that dimension is k-1, it travels over the wrap-around link, and the packet is promoted to the next virtual-channel level. With one extra level per dimension, every route climbs a strictly ordered set of channel resources, so the channel dependences cannot form a cycle.

Top module: `tr_route`

## Requirements
- R1: After reset `route_valid` is 0 and `hdr_ready` is 1.
- R2: A header is taken on a clock edge where `hdr_valid` and `hdr_ready` are both 1; `route_valid` is 1 from that edge onward until the result is taken.
- R3: While `route_valid` is 1 and `route_ready` is 0, `hdr_ready` is 0 and `route_port`, `route_lvl` and `route_eject` hold their values.
- R4: Coordinates are packed with dimension d in bits [d*CW +: CW]. For a header not at its destination, `route_port` is the index d of the lowest dimension where current and destination coordinates differ; port d means the link that increments coordinate d modulo K. A full walk therefore takes exactly the sum over dimensions of (dst - src) mod K hops.
- R5: If the selected dimension's current coordinate equals K-1 (the wrap-around hop), `route_lvl` is the input level plus one, saturating at N; otherwise `route_lvl` equals the input level.
- R6: When all coordinates match, `route_eject` is 1, `route_port` equals N (the local ejection port) and `route_lvl` equals the input level.
- R7: Along any route started at level 0, the level never decreases from hop to hop and never exceeds N.
- R8: With `route_ready` held at 1, a new header is accepted on every clock edge, so results stream without idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header slot can take a header this cycle |
| hdr_cur | input | N*CW | Coordinates of this node, dimension d in bits [d*CW +: CW] |
| hdr_dst | input | N*CW | Destination coordinates, same packing |
| hdr_lvl | input | LW | Virtual-channel level the packet arrived on (0..N) |
| route_valid | output | 1 | A routing result is present |
| route_ready | input | 1 | Downstream takes the result this cycle |
| route_port | output | LW | Output port: 0..N-1 a dimension link, N the ejection port |
| route_lvl | output | LW | Virtual-channel level to use on the selected port |
| route_eject | output | 1 | Packet has reached its destination |

## Verification
On every cycle the assertions check that a stalled result stays frozen, that an accepted header produces a result, that the outgoing level is never below the arriving level nor above N, that ejection is only flagged when coordinates match and that a non-eject port names a real dimension. Only the bench scenarios show that the chosen dimension is the lowest differing one, that the level rises exactly at the wrap-around hop, that walks between every pair of nodes reach their destination in the minimal number of hops, and that headers stream back to back under full throughput.

// File: rtl/tr_pkg.sv
package tr_pkg;

  // Default network shape: 4-ary 2-cube.
  localparam int unsigned TR_K_DEF = 4;
  localparam int unsigned TR_N_DEF = 2;

  // Occupancy of the one-entry header slot.
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_e;

endpackage

// File: rtl/tr_hdr_slot.sv
module tr_hdr_slot
  import tr_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  slot_e        state_q, state_d;
  logic [W-1:0] data_q;
  logic         load_en;

  assign in_ready  = (state_q == SLOT_EMPTY) || out_ready;
  assign load_en   = in_valid && in_ready;
  assign out_valid = (state_q == SLOT_FULL);
  assign out_data  = data_q;

  always_comb begin
    state_d = state_q;
    if (load_en) begin
      state_d = SLOT_FULL;
    end else if (out_ready) begin
      state_d = SLOT_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
    end else begin
      state_q <= state_d;
    end
  end

  // Datapath register: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= in_data;
    end
  end

  AST_TAKE_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid) else $error("take without result"); // R2

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)) else $error("stalled slot changed"); // R3

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready) else $error("slot accepts while stalled"); // R3

endmodule

// File: rtl/tr_dim_pick.sv
module tr_dim_pick #(
  parameter int unsigned N  = 2,
  parameter int unsigned CW = 2,
  parameter int unsigned PW = 2
) (
  input  logic [N*CW-1:0] cur,
  input  logic [N*CW-1:0] dst,
  output logic [N-1:0]    sel,
  output logic [PW-1:0]   sel_idx,
  output logic            arrived
);

  logic [N-1:0] differs;
  logic [N:0]   seen_lower;

  assign seen_lower[0] = 1'b0;

  genvar gd;
  generate
    for (gd = 0; gd < N; gd++) begin : g_dim
      assign differs[gd]      = (cur[gd*CW +: CW] != dst[gd*CW +: CW]);
      assign sel[gd]          = differs[gd] && !seen_lower[gd];
      assign seen_lower[gd+1] = seen_lower[gd] || differs[gd];
    end
  endgenerate

  assign arrived = !seen_lower[N];

  always_comb begin
    sel_idx = '0;
    for (int d = 0; d < N; d++) begin
      if (sel[d]) begin
        sel_idx = sel_idx | PW'(d);
      end
    end
  end

endmodule

// File: rtl/tr_lvl_step.sv
module tr_lvl_step #(
  parameter int unsigned K  = 4,
  parameter int unsigned N  = 2,
  parameter int unsigned CW = 2,
  parameter int unsigned LW = 2
) (
  input  logic [N*CW-1:0] cur,
  input  logic [N-1:0]    sel,
  input  logic            arrived,
  input  logic [LW-1:0]   lvl_in,
  output logic [LW-1:0]   lvl_out
);

  localparam logic [CW-1:0] EDGE = CW'(K - 1);
  localparam logic [LW-1:0] LMAX = LW'(N);

  logic [N-1:0] at_edge;
  logic         wraps;

  genvar gd;
  generate
    for (gd = 0; gd < N; gd++) begin : g_edge
      assign at_edge[gd] = (cur[gd*CW +: CW] == EDGE);
    end
  endgenerate

  assign wraps = |(sel & at_edge);

  always_comb begin
    lvl_out = lvl_in;
    if (!arrived && wraps && (lvl_in < LMAX)) begin
      lvl_out = lvl_in + 1'b1;
    end
  end

endmodule

// File: rtl/tr_route.sv
module tr_route
  import tr_pkg::*;
#(
  parameter int unsigned K  = TR_K_DEF,
  parameter int unsigned N  = TR_N_DEF,
  parameter int unsigned CW = (K > 1) ? $clog2(K) : 1,
  parameter int unsigned LW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hdr_valid,
  output logic            hdr_ready,
  input  logic [N*CW-1:0] hdr_cur,
  input  logic [N*CW-1:0] hdr_dst,
  input  logic [LW-1:0]   hdr_lvl,
  output logic            route_valid,
  input  logic            route_ready,
  output logic [LW-1:0]   route_port,
  output logic [LW-1:0]   route_lvl,
  output logic            route_eject
);

  localparam int unsigned    HW   = 2 * N * CW + LW;
  localparam logic [LW-1:0]  LMAX = LW'(N);
  localparam logic [LW-1:0]  EJP  = LW'(N);

  logic [HW-1:0]   slot_in, slot_out;
  logic [N*CW-1:0] held_cur, held_dst;
  logic [LW-1:0]   held_lvl;
  logic [N-1:0]    dim_sel;
  logic [LW-1:0]   dim_idx;
  logic            at_dest;
  logic [LW-1:0]   next_lvl;

  assign slot_in = {hdr_cur, hdr_dst, hdr_lvl};

  tr_hdr_slot #(.W(HW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (hdr_valid),
    .in_ready  (hdr_ready),
    .in_data   (slot_in),
    .out_valid (route_valid),
    .out_ready (route_ready),
    .out_data  (slot_out)
  );

  assign held_cur = slot_out[HW-1 -: N*CW];
  assign held_dst = slot_out[LW +: N*CW];
  assign held_lvl = slot_out[LW-1:0];

  tr_dim_pick #(.N(N), .CW(CW), .PW(LW)) u_pick (
    .cur     (held_cur),
    .dst     (held_dst),
    .sel     (dim_sel),
    .sel_idx (dim_idx),
    .arrived (at_dest)
  );

  tr_lvl_step #(.K(K), .N(N), .CW(CW), .LW(LW)) u_lvl (
    .cur     (held_cur),
    .sel     (dim_sel),
    .arrived (at_dest),
    .lvl_in  (held_lvl),
    .lvl_out (next_lvl)
  );

  assign route_port  = at_dest ? EJP : dim_idx;
  assign route_lvl   = next_lvl;
  assign route_eject = at_dest;

  AST_LVL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> route_lvl >= held_lvl) else $error("level dropped"); // R7

  AST_LVL_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && (held_lvl <= LMAX) |-> route_lvl <= LMAX) else $error("level above N"); // R7

  AST_EJECT_ONLY_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && route_eject |-> (held_cur == held_dst) && (route_lvl == held_lvl)) else $error("bad eject"); // R6

  AST_PORT_IS_DIM: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && !route_eject |-> (route_port < EJP) && (held_cur != held_dst)) else $error("bad port"); // R4

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> route_lvl <= held_lvl + 1'b1) else $error("level jumped"); // R5

endmodule

// File: tb/sim_tr_route.sv
module sim_tr_route;

  localparam int K  = 4;
  localparam int N  = 2;
  localparam int CW = 2;
  localparam int LW = 2;

  typedef struct {
    logic [LW-1:0] port;
    logic [LW-1:0] lvl;
    logic          eject;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            hdr_valid;
  logic            hdr_ready;
  logic [N*CW-1:0] hdr_cur;
  logic [N*CW-1:0] hdr_dst;
  logic [LW-1:0]   hdr_lvl;
  logic            route_valid;
  logic            route_ready;
  logic [LW-1:0]   route_port;
  logic [LW-1:0]   route_lvl;
  logic            route_eject;

  int checks = 0;
  int errors = 0;
  int pops   = 0;
  bit done   = 0;
  exp_t q[$];
  exp_t last;

  always #10 clk = ~clk;  // 50 MHz

  tr_route #(.K(K), .N(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_cur(hdr_cur), .hdr_dst(hdr_dst), .hdr_lvl(hdr_lvl),
    .route_valid(route_valid), .route_ready(route_ready),
    .route_port(route_port), .route_lvl(route_lvl), .route_eject(route_eject)
  );

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic exp_t model(logic [N*CW-1:0] c, logic [N*CW-1:0] d, logic [LW-1:0] l);
    exp_t e;
    e.port = LW'(N); e.lvl = l; e.eject = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (c[i*CW +: CW] != d[i*CW +: CW]) begin
        e.port  = LW'(i);
        e.eject = 1'b0;
        e.lvl   = (c[i*CW +: CW] == CW'(K - 1) && l < LW'(N)) ? l + 1'b1 : l;
      end
    end
    return e;
  endfunction

  // Driver: called just after a falling edge, returns just after the next one.
  task automatic send(logic [N*CW-1:0] c, logic [N*CW-1:0] d, logic [LW-1:0] l, output int waited);
    hdr_cur = c; hdr_dst = d; hdr_lvl = l; hdr_valid = 1'b1;
    waited = 0;
    #1;
    while (!hdr_ready) begin
      @(negedge clk); #1;
      waited++;
    end
    q.push_back(model(c, d, l));
    @(negedge clk);
  endtask

  task automatic idle();
    hdr_valid = 1'b0;
  endtask

  // Monitor: pops and compares each result as it is taken.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && route_valid && route_ready) begin
        if (q.size() == 0) begin
          check(0, "R2 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(route_port == e.port, e.eject ? "R6 eject port" : "R4 port", route_port, e.port);
          check(route_lvl == e.lvl, e.eject ? "R6 level" : "R5 level", route_lvl, e.lvl);
          check(route_eject == e.eject, "R6 eject flag", route_eject, e.eject);
          last.port = route_port; last.lvl = route_lvl; last.eject = route_eject;
          pops++;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic walk(int src, int dst);
    logic [N*CW-1:0] c;
    logic [LW-1:0] l;
    int hops, want, w, p0;
    c = (N*CW)'(src); l = '0; hops = 0; want = 0;
    for (int i = 0; i < N; i++)
      want += (dst / (1 << (i*CW)) % K - src / (1 << (i*CW)) % K + K) % K;
    forever begin
      p0 = pops;
      send(c, (N*CW)'(dst), l, w);
      idle();
      while (pops == p0) begin @(negedge clk); #3; end
      check(last.lvl >= l && last.lvl <= LW'(N), "R7 level monotonic and capped", last.lvl, l);
      if (last.eject || hops > N * K) break;
      c[last.port*CW +: CW] = c[last.port*CW +: CW] + 1'b1;
      l = last.lvl;
      hops++;
      @(negedge clk);
    end
    check(hops == want, "R4 minimal hop count", hops, want);
  endtask

  initial begin
    int w;
    exp_t held;
    rst_n = 1'b0; hdr_valid = 1'b0; route_ready = 1'b0;
    hdr_cur = '0; hdr_dst = '0; hdr_lvl = '0;
    repeat (3) @(negedge clk);
    #1;
    check(route_valid == 1'b0, "R1 valid after reset", route_valid, 0);
    check(hdr_ready == 1'b1, "R1 ready after reset", hdr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: stall holds result and blocks the next header.
    send(4'b0011, 4'b1001, 2'd0, w);  // dim0 at K-1 -> wrap, level 1
    check(route_valid == 1'b1, "R2 valid after take", route_valid, 1);
    held.port = route_port; held.lvl = route_lvl;
    hdr_cur = 4'b0000; hdr_dst = 4'b0100; hdr_lvl = 2'd0; hdr_valid = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check(hdr_ready == 1'b0, "R3 ready low while stalled", hdr_ready, 0);
      check(route_port == held.port && route_lvl == held.lvl, "R3 result frozen", route_lvl, held.lvl);
    end
    route_ready = 1'b1;
    send(4'b0000, 4'b0100, 2'd0, w);
    idle();
    repeat (3) @(negedge clk);

    // R5: saturation at N and no wrap off the edge.
    send(4'b1100, 4'b0000, 2'd2, w);  // dim1 at K-1, level already N
    send(4'b0101, 4'b0110, 2'd1, w);  // dim0 not at edge, level kept
    send(4'b1010, 4'b1010, 2'd1, w);  // R6 eject keeps level
    check(w == 0, "R8 back-to-back accept", w, 0);
    send(4'b0111, 4'b1011, 2'd0, w);
    check(w == 0, "R8 back-to-back accept", w, 0);
    idle();
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R8 all results drained", q.size(), 0);

    // R4, R5, R6, R7: every source/destination pair.
    for (int s = 0; s < K**N; s++)
      for (int d = 0; d < K**N; d++)
        walk(s, d);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule